// File: doc/BRIEF.md
# SPI Hold Pause Controller

This block gives an SPI slave its pause function. It runs on the system clock and takes three inputs that are already synchronized: the active-low chip select, the serial clock and the active-low hold pin. A pause starts or ends only while the serial clock is low. A change on the hold pin that arrives while the clock is high waits until the clock next goes low. During a pause, the block drives the serial output to high impedance. It also withholds the capture and launch enables, so the downstream shift register and bit counter keep their state.

The command decoder sits downstream and is not part of this block. It sees two things: a pair of clock-edge enables, gated by the pause, and a one-cycle reset pulse. The pulse fires when the slave is deselected during a pause, and it drops the pause at the same clock edge.

Top module: `spi_hold_ctrl`

## Requirements
- R1: While cs_n is sampled high, hold_active is 0 at the next clock, and so_hiz is 1 whenever cs_n is 1.
- R2: When cs_n is 0, sck is 0 and hold_n is 0 at a clock edge, hold_active is 1 after that edge.
- R3: When sck is sampled 1, hold_active keeps its previous value whatever hold_n does. A hold_n edge seen during sck high takes effect at the first edge that samples sck 0.
- R4: When cs_n is 0, sck is 0 and hold_n is 1 at a clock edge, hold_active is 0 after that edge.
- R5: While hold_active is 1, so_hiz is 1 and rx_ce and tx_ce are both 0.
- R6: When not held and cs_n is 0, rx_ce is 1 in the cycle where sck is 1 and the previous clock sampled it 0. tx_ce is 1 in the cycle where sck is 0 and the previous clock sampled it 1.
- R7: If cs_n is sampled 1 while hold_active is 1, cmd_rst is 1 for exactly one clock and hold_active is 0 after the same edge. A deselect without a pause gives no pulse.
- R8: A synchronous rst clears hold_active and cmd_rst.
- R9: Across a pause, the number of rx_ce pulses equals the number of sck rising edges that occur outside the pause, with none lost and none added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Synchronized chip select, active low |
| sck | input | 1 | Synchronized serial clock level |
| hold_n | input | 1 | Synchronized hold pin, active low |
| hold_active | output | 1 | Pause in effect |
| so_hiz | output | 1 | Serial output must float |
| rx_ce | output | 1 | Capture enable on sck rise, gated by pause |
| tx_ce | output | 1 | Launch enable on sck fall, gated by pause |
| cmd_rst | output | 1 | One-cycle reset for the command logic |

## Verification
The bench builds the block with the default edge-history reset level of 0, and it holds sck low across reset, so the first edge it drives is a real rise. With that setting, every enter, defer and exit ordering can be reached from a short level table. The directed part checks the edge enables in the cycle they appear. It then drives a multi-period sck burst with a pause in the middle, which exposes any lost or spurious capture edge at resume.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

    typedef enum logic {
        PH_RUN  = 1'b0,
        PH_HELD = 1'b1
    } hold_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } sck_edge_t;

    typedef struct packed {
        logic rx_ce;
        logic tx_ce;
        logic so_hiz;
    } gate_out_t;

    // Next pause state: deselect always clears, the low phase of sck
    // follows the pin, the high phase keeps the current state.
    function automatic hold_state_e next_hold(input hold_state_e cur,
                                              input logic cs_n,
                                              input logic sck,
                                              input logic hold_n);
        hold_state_e nxt;
        if (cs_n)
            nxt = PH_RUN;
        else if (!sck)
            nxt = hold_n ? PH_RUN : PH_HELD;
        else
            nxt = cur;
        return nxt;
    endfunction

endpackage

// File: rtl/spi_hold_edge.sv
module spi_hold_edge
    import spi_hold_pkg::*;
#(
    parameter logic SCK_RST_LVL = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sck,
    output sck_edge_t edge_o
);
    logic sck_d;

    always_ff @(posedge clk) begin
        if (rst)
            sck_d <= SCK_RST_LVL;
        else
            sck_d <= sck;
    end

    always_comb begin
        edge_o.rise = sck & ~sck_d;
        edge_o.fall = ~sck & sck_d;
    end
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
    import spi_hold_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        sck,
    input  logic        hold_n,
    output hold_state_e state_o,
    output logic        cmd_rst_o
);
    hold_state_e state_q;
    logic        rst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_RUN;
            rst_q   <= 1'b0;
        end else begin
            rst_q   <= (state_q == PH_HELD) && cs_n;
            state_q <= next_hold(state_q, cs_n, sck, hold_n);
        end
    end

    assign state_o   = state_q;
    assign cmd_rst_o = rst_q;
endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
    import spi_hold_pkg::*;
(
    input  logic        cs_n,
    input  hold_state_e state_i,
    input  sck_edge_t   edge_i,
    output gate_out_t   gate_o
);
    logic run;

    always_comb begin
        run           = !cs_n && (state_i == PH_RUN);
        gate_o.rx_ce  = run && edge_i.rise;
        gate_o.tx_ce  = run && edge_i.fall;
        gate_o.so_hiz = !run;
    end
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
    import spi_hold_pkg::*;
#(
    parameter logic SCK_RST_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    output logic hold_active,
    output logic so_hiz,
    output logic rx_ce,
    output logic tx_ce,
    output logic cmd_rst
);
    sck_edge_t   sck_edge;
    hold_state_e state;
    gate_out_t   gate;

    spi_hold_edge #(.SCK_RST_LVL(SCK_RST_LVL)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .sck    (sck),
        .edge_o (sck_edge)
    );

    spi_hold_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .sck       (sck),
        .hold_n    (hold_n),
        .state_o   (state),
        .cmd_rst_o (cmd_rst)
    );

    spi_hold_gate u_gate (
        .cs_n    (cs_n),
        .state_i (state),
        .edge_i  (sck_edge),
        .gate_o  (gate)
    );

    assign hold_active = (state == PH_HELD);
    assign so_hiz      = gate.so_hiz;
    assign rx_ce       = gate.rx_ce;
    assign tx_ce       = gate.tx_ce;
endmodule

// File: rtl/spi_hold_ctrl_chk.sv
module spi_hold_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sck,
    input logic hold_n,
    input logic hold_active,
    input logic so_hiz,
    input logic rx_ce,
    input logic tx_ce,
    input logic cmd_rst
);
    // R1
    deselect_clears_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !hold_active);

    // R2
    enter_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !sck && !hold_n) |=> hold_active);

    // R3
    high_phase_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && sck) |=> $stable(hold_active));

    // R4
    exit_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !sck && hold_n) |=> !hold_active);

    // R5
    held_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        hold_active |-> (so_hiz && !rx_ce && !tx_ce));

    // R7
    reset_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_active && cs_n) |=> (cmd_rst && !hold_active));

    // R7
    reset_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_rst |=> !cmd_rst);

    // R8
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!hold_active && !cmd_rst));
endmodule

bind spi_hold_ctrl spi_hold_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .sck         (sck),
    .hold_n      (hold_n),
    .hold_active (hold_active),
    .so_hiz      (so_hiz),
    .rx_ce       (rx_ce),
    .tx_ce       (tx_ce),
    .cmd_rst     (cmd_rst)
);

// File: tb/tb_spi_hold_ctrl.sv
`timescale 1ns/1ps
module tb_spi_hold_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic hold_n = 1'b1;
    logic hold_active, so_hiz, rx_ce, tx_ce, cmd_rst;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    spi_hold_ctrl dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
        .hold_active(hold_active), .so_hiz(so_hiz), .rx_ce(rx_ce),
        .tx_ce(tx_ce), .cmd_rst(cmd_rst)
    );

    // {cs_n, sck, hold_n, exp_hold, exp_hiz, exp_rst}
    localparam int NV = 19;
    localparam logic [5:0] VEC [0:NV-1] = '{
        6'b101_010, // R1 idle
        6'b001_000, // R1 selected, running
        6'b000_110, // R2 enter in low phase
        6'b010_110, // R3 high phase keeps hold
        6'b011_110, // R3 release deferred
        6'b001_000, // R4 exit at low phase
        6'b011_000, // R3
        6'b010_000, // R3 fall deferred
        6'b010_000, // R3
        6'b000_110, // R2 deferred entry lands
        6'b001_000, // R4 immediate exit
        6'b000_110, // R2
        6'b100_011, // R7 deselect in pause
        6'b100_010, // R7 single pulse
        6'b101_010, // R1
        6'b100_010, // R1 pin ignored while deselected
        6'b000_110, // R2 reselect with pin low
        6'b001_000, // R4
        6'b101_010  // R7 deselect when running, no pulse
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1, 14, 15: return "R1";
            2, 9, 11, 16: return "R2";
            5, 10, 17:    return "R4";
            12, 13, 18:   return "R7";
            default:      return "R3";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic s, input logic h);
        @(negedge clk);
        cs_n = c; sck = s; hold_n = h;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int cnt;
        repeat (3) @(posedge clk);
        #1;
        // R8 reset state
        check("R8", "hold_active after reset", hold_active, 1'b0);
        check("R8", "cmd_rst after reset", cmd_rst, 1'b0);
        check("R1", "so_hiz deselected", so_hiz, 1'b1);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][5], VEC[i][4], VEC[i][3]);
            check(vec_tag(i), "hold_active", hold_active, VEC[i][2]);
            check(vec_tag(i), "so_hiz", so_hiz, VEC[i][1]);
            check(vec_tag(i), "cmd_rst", cmd_rst, VEC[i][0]);
        end

        // R6 edge enables while running
        step(1'b0, 1'b0, 1'b1);
        @(negedge clk); sck = 1'b1; #1;
        check("R6", "rx_ce on rise", rx_ce, 1'b1);
        check("R6", "tx_ce on rise", tx_ce, 1'b0);
        @(posedge clk); #1;
        check("R6", "rx_ce after rise", rx_ce, 1'b0);
        @(negedge clk); sck = 1'b0; #1;
        check("R6", "tx_ce on fall", tx_ce, 1'b1);
        check("R6", "rx_ce on fall", rx_ce, 1'b0);

        // R5 quiet during pause
        step(1'b0, 1'b0, 1'b0);
        check("R5", "held", hold_active, 1'b1);
        @(negedge clk); sck = 1'b1; #1;
        check("R5", "rx_ce held", rx_ce, 1'b0);
        check("R5", "so_hiz held", so_hiz, 1'b1);
        @(negedge clk); sck = 1'b0; #1;
        check("R5", "tx_ce held", tx_ce, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        check("R4", "resume", hold_active, 1'b0);

        // R9 burst with a pause in the middle
        cnt = 0;
        for (int p = 0; p < 8; p++) begin
            @(negedge clk);
            sck = 1'b0;
            hold_n = (p == 3 || p == 4) ? 1'b0 : 1'b1;
            @(negedge clk);
            sck = 1'b1;
            #1;
            if (rx_ce) cnt++;
        end
        check("R9", "capture count is 6", (cnt == 6), 1'b1);
        if (cnt != 6) $display("R9 note: count actual=%0d expected=6", cnt);

        // R8 reset during a pause
        step(1'b0, 1'b0, 1'b0);
        check("R2", "held before reset", hold_active, 1'b1);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R8", "reset clears hold", hold_active, 1'b0);
        check("R8", "reset no pulse", cmd_rst, 1'b0);
        @(negedge clk); rst = 1'b0; cs_n = 1'b1; hold_n = 1'b1;
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule